// File: doc/BRIEF.md
# Framed Serial Read Port for a Converter Result

This block is the read side of a converter's serial port when the host supplies the serial clock. It holds one 24-bit word at a time. That word is either the latest conversion result or one of several configuration words, picked by an index. The word goes out most significant bit first on a data line that can be switched off. The host drives three signals: the serial clock, an active-low frame select, and an address select. The block drives an active-low ready flag, the data value and the data enable.

The serial clock and the frame select are brought into the system clock domain through synchronizers, and their edges are detected there. A sequencer has three named states:

- `ST_IDLE`: no word in flight.
- `ST_SEND`: a frame is open and bits are going out.
- `ST_HOLD`: the frame was closed partway through a word.

The transitions are:

- IDLE to SEND: the frame falls and a word is allowed to start.
- SEND to SEND: a falling serial clock edge advances one bit.
- SEND to HOLD: the frame rises partway through a word.
- HOLD to SEND: the frame falls again.
- SEND to IDLE: the falling edge after the last bit.

A result buffer loads new conversion results and pulls the ready flag low. It holds back a result that arrives while the result word is being read. The ready flag is released only when the last bit has been clocked out.

Top module: `srd_read_port`

## Requirements
- R1: After reset the ready flag `drdy_n_o` is high (1) and the data enable `sdo_en_o` is low.
- R2: A one-cycle pulse on `res_valid_i` while no result read is in progress loads `res_data_i` as the result word and drives `drdy_n_o` low.
- R3: When the frame select falls with address select 0 (result word) and `drdy_n_o` low, `sdo_en_o` goes high and `sdo_o` shows bit 23 of the word before any serial clock edge.
- R4: Each falling serial clock edge moves `sdo_o` to the next lower bit, so bit 23-k is shown after the k-th falling edge.
- R5: The 23rd falling edge shows bit 0. The 24th falling edge turns `sdo_en_o` off and, for a result read, drives `drdy_n_o` high. Further clock edges do not turn the output back on until a new frame starts.
- R6: Raising the frame select partway through a word turns `sdo_en_o` off, leaves `drdy_n_o` unchanged and keeps the bit position. A later falling frame select resumes with the next unsent bit, and this may repeat any number of times.
- R7: With address select 1, the configuration word selected by `reg_idx_i` (bits [24*i+23 : 24*i] of `regs_i`) is sent as 24 bits whatever the state of `drdy_n_o`. Such a read leaves `drdy_n_o` untouched, and a result arriving during it may pull `drdy_n_o` low without disturbing the transfer.
- R8: The address select and the index are sampled only on the frame fall that starts a word. Changing them while a word is paused has no effect on the bits that follow.
- R9: A result arriving during a result read is held. The read finishes with the old word, `drdy_n_o` rises, and the held value then becomes the result word with `drdy_n_o` low again.
- R10: A frame fall with address select 0 while `drdy_n_o` is high starts nothing, and `sdo_en_o` stays low through any clock edges in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host serial clock, idles low |
| rfs_n_i | input | 1 | Active-low read frame select |
| addr_sel_i | input | 1 | 0 selects the result word, 1 selects a configuration word |
| reg_idx_i | input | IDX_W | Index of the configuration word |
| regs_i | input | NREG*W | Configuration words, word i in bits [W*i+W-1 : W*i] |
| res_valid_i | input | 1 | One-cycle strobe for a new conversion result |
| res_data_i | input | W | New conversion result |
| drdy_n_o | output | 1 | Active-low result-ready flag |
| sdo_o | output | 1 | Serial data value |
| sdo_en_o | output | 1 | Serial data drive enable; off means high impedance |

## Verification
Two events can land in the same window: a new result strobe and the final falling edge that ends a result read. When they coincide, the buffer must park the result and still release the ready flag. The bench provokes this by firing strobes inside result reads at random bit positions, including positions near the end. A reference model judges each case: the old word must finish bit for bit, the ready flag must be high exactly when no result is pending, and the next read must return the parked value.

// File: rtl/srd_pkg.sv
package srd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_HOLD
    } seq_state_t;

    typedef enum logic {
        SRC_RESULT,
        SRC_REGFILE
    } word_src_t;

endpackage

// File: rtl/srd_edge_sync.sv
module srd_edge_sync #(
    parameter int STAGES   = 2,
    parameter bit IDLE_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {STAGES{IDLE_LVL}};
            prev_q <= IDLE_LVL;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign level  = sync_q[STAGES-1];
    assign rise_o = level & ~prev_q;
    assign fall_o = ~level & prev_q;

endmodule

// File: rtl/srd_result_buf.sv
module srd_result_buf #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         res_valid_i,
    input  logic [W-1:0] res_data_i,
    input  logic         reading_i,
    input  logic         data_done_i,
    output logic [W-1:0] out_word_o,
    output logic         drdy_n_o
);

    logic [W-1:0] word_q;
    logic [W-1:0] pend_q;
    logic         pend_v_q;
    logic         drdy_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q   <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            drdy_n_q <= 1'b1;
        end else begin
            if (res_valid_i && reading_i) begin
                pend_q   <= res_data_i;
                pend_v_q <= 1'b1;
            end else if (res_valid_i) begin
                word_q   <= res_data_i;
                drdy_n_q <= 1'b0;
                pend_v_q <= 1'b0;
            end else if (pend_v_q && !reading_i) begin
                word_q   <= pend_q;
                drdy_n_q <= 1'b0;
                pend_v_q <= 1'b0;
            end
            if (data_done_i) begin
                drdy_n_q <= 1'b1;
            end
        end
    end

    assign out_word_o = word_q;
    assign drdy_n_o   = drdy_n_q;

    AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        data_done_i |=> drdy_n_o); // R5
    AST_READ_KEEPS_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (reading_i && !data_done_i) |=> !drdy_n_o); // R6
    AST_HELD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && reading_i) |=> pend_v_q); // R9

endmodule

// File: rtl/srd_shift_seq.sv
module srd_shift_seq
    import srd_pkg::*;
#(
    parameter int W     = 24,
    parameter int CNT_W = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_fall_i,
    input  logic         rfs_fall_i,
    input  logic         rfs_rise_i,
    input  logic         addr_sel_i,
    input  logic         drdy_n_i,
    input  logic [W-1:0] data_word_i,
    input  logic [W-1:0] reg_word_i,
    output logic         sdo_o,
    output logic         sdo_en_o,
    output logic         reading_data_o,
    output logic         data_done_o
);

    seq_state_t       state_q, state_d;
    word_src_t        src_q, src_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [W-1:0]     word_q, word_d;
    logic             last_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= SRC_RESULT;
            cnt_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
            cnt_q   <= cnt_d;
            word_q  <= word_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        src_d     = src_q;
        cnt_d     = cnt_q;
        word_d    = word_q;
        last_fall = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rfs_fall_i) begin
                    if (addr_sel_i) begin
                        word_d  = reg_word_i;
                        src_d   = SRC_REGFILE;
                        cnt_d   = '0;
                        state_d = ST_SEND;
                    end else if (!drdy_n_i) begin
                        word_d  = data_word_i;
                        src_d   = SRC_RESULT;
                        cnt_d   = '0;
                        state_d = ST_SEND;
                    end
                end
            end
            ST_SEND: begin
                if (sclk_fall_i) begin
                    if (cnt_q == CNT_W'(W-1)) begin
                        last_fall = 1'b1;
                        state_d   = ST_IDLE;
                    end else begin
                        cnt_d  = cnt_q + 1'b1;
                        word_d = {word_q[W-2:0], 1'b0};
                    end
                end
                if (rfs_rise_i && !last_fall) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (rfs_fall_i) begin
                    state_d = ST_SEND;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sdo_en_o       = (state_q == ST_SEND);
        sdo_o          = word_q[W-1];
        reading_data_o = (state_q != ST_IDLE) && (src_q == SRC_RESULT);
        data_done_o    = last_fall && (src_q == SRC_RESULT);
    end

    AST_FRAME_UP_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        (rfs_rise_i && state_q == ST_SEND) |=> !sdo_en_o); // R6
    AST_HOLD_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (cnt_q == $past(cnt_q))); // R6
    AST_LAST_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        last_fall |=> !sdo_en_o); // R5
    AST_NO_START_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rfs_fall_i && !addr_sel_i && drdy_n_i) |=> !sdo_en_o); // R10

endmodule

// File: rtl/srd_read_port.sv
module srd_read_port
    import srd_pkg::*;
#(
    parameter int W           = 24,
    parameter int NREG        = 4,
    parameter int IDX_W       = (NREG > 1) ? $clog2(NREG) : 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              rfs_n_i,
    input  logic              addr_sel_i,
    input  logic [IDX_W-1:0]  reg_idx_i,
    input  logic [NREG*W-1:0] regs_i,
    input  logic              res_valid_i,
    input  logic [W-1:0]      res_data_i,
    output logic              drdy_n_o,
    output logic              sdo_o,
    output logic              sdo_en_o
);

    logic         sclk_rise, sclk_fall;
    logic         rfs_rise, rfs_fall;
    logic         reading_data, data_done;
    logic [W-1:0] data_word, reg_word;
    logic [W-1:0] reg_arr [NREG];

    srd_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b0)) i_sclk_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sclk_i),
        .rise_o  (sclk_rise),
        .fall_o  (sclk_fall)
    );

    srd_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) i_rfs_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rfs_n_i),
        .rise_o  (rfs_rise),
        .fall_o  (rfs_fall)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_regs
        assign reg_arr[g] = regs_i[g*W +: W];
    end

    assign reg_word = reg_arr[reg_idx_i];

    srd_result_buf #(.W(W)) i_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_valid_i (res_valid_i),
        .res_data_i  (res_data_i),
        .reading_i   (reading_data),
        .data_done_i (data_done),
        .out_word_o  (data_word),
        .drdy_n_o    (drdy_n_o)
    );

    srd_shift_seq #(.W(W)) i_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .sclk_fall_i    (sclk_fall),
        .rfs_fall_i     (rfs_fall),
        .rfs_rise_i     (rfs_rise),
        .addr_sel_i     (addr_sel_i),
        .drdy_n_i       (drdy_n_o),
        .data_word_i    (data_word),
        .reg_word_i     (reg_word),
        .sdo_o          (sdo_o),
        .sdo_en_o       (sdo_en_o),
        .reading_data_o (reading_data),
        .data_done_o    (data_done)
    );

    AST_RISE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> $stable(sdo_o)); // R4

endmodule

// File: tb/test_srd_read_port.sv
module test_srd_read_port;
    localparam int W = 24;
    localparam int NREG = 4;
    localparam int IDX_W = 2;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              sclk, rfs_n, addr_sel, res_valid;
    logic [IDX_W-1:0]  reg_idx;
    logic [NREG*W-1:0] regs_flat;
    logic [W-1:0]      res_data;
    logic              drdy_n, sdo, sdo_en;

    srd_read_port i_srd_read_port (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .rfs_n_i(rfs_n),
        .addr_sel_i(addr_sel), .reg_idx_i(reg_idx), .regs_i(regs_flat),
        .res_valid_i(res_valid), .res_data_i(res_data),
        .drdy_n_o(drdy_n), .sdo_o(sdo), .sdo_en_o(sdo_en)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;
    logic [W-1:0] m_out = '0, m_pend = '0;
    bit m_pend_v = 0, m_drdy_n = 1, m_reading = 0;
    logic [W-1:0] regs [NREG];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [W-1:0] d);
        res_data = d;
        res_valid = 1'b1;
        wt(1);
        res_valid = 1'b0;
        if (m_reading) begin
            m_pend = d;
            m_pend_v = 1;
        end else begin
            m_out = d;
            m_drdy_n = 0;
            m_pend_v = 0;
        end
    endtask

    task automatic pulse();
        sclk = 1'b1; wt(HALF);
        sclk = 1'b0; wt(HALF);
    endtask

    // split_mode: 0 none, 1 after every bit, 2 random
    task automatic read_word(input bit a, input int idx, input int split_mode,
                             input int push_at, input logic [W-1:0] push_val);
        logic [W-1:0] exp;
        bit data_rd, started, do_split;
        string dtag;
        data_rd = (a == 1'b0);
        exp = data_rd ? m_out : regs[idx];
        started = data_rd ? !m_drdy_n : 1'b1;
        dtag = data_rd ? "R6" : "R7";
        addr_sel = a;
        reg_idx = IDX_W'(idx);
        rfs_n = 1'b0;
        wt(HALF);
        if (!started) begin
            chk(sdo_en == 1'b0, "R10", 32'(sdo_en), 32'd0);
            pulse(); pulse();
            chk(sdo_en == 1'b0, "R10", 32'(sdo_en), 32'd0);
            rfs_n = 1'b1; wt(HALF);
            return;
        end
        if (data_rd) m_reading = 1;
        chk(sdo_en && sdo == exp[W-1], "R3", {30'd0, sdo_en, sdo}, {30'd0, 1'b1, exp[W-1]});
        for (int i = 1; i <= W; i++) begin
            pulse();
            if (i < W) begin
                chk(sdo_en && sdo == exp[W-1-i], (i == W-1) ? "R5" : "R4",
                    {30'd0, sdo_en, sdo}, {30'd0, 1'b1, exp[W-1-i]});
                if (i == push_at) push(push_val);
                chk(drdy_n == m_drdy_n, dtag, 32'(drdy_n), 32'(m_drdy_n));
                do_split = (split_mode == 1) || (split_mode == 2 && ($urandom % 5) == 0);
                if (do_split) begin
                    rfs_n = 1'b1; wt(HALF);
                    chk(!sdo_en, "R6", 32'(sdo_en), 32'd0);
                    chk(drdy_n == m_drdy_n, dtag, 32'(drdy_n), 32'(m_drdy_n));
                    addr_sel = ~a;
                    reg_idx = IDX_W'(idx + 1);
                    wt(2);
                    rfs_n = 1'b0; wt(HALF);
                    chk(sdo_en && sdo == exp[W-1-i], "R8",
                        {30'd0, sdo_en, sdo}, {30'd0, 1'b1, exp[W-1-i]});
                end
            end
        end
        if (data_rd) begin
            m_reading = 0;
            m_drdy_n = 1;
            if (m_pend_v) begin
                m_out = m_pend;
                m_drdy_n = 0;
                m_pend_v = 0;
            end
        end
        chk(!sdo_en, "R5", 32'(sdo_en), 32'd0);
        chk(drdy_n == m_drdy_n, data_rd ? "R9" : "R7", 32'(drdy_n), 32'(m_drdy_n));
        pulse();
        chk(!sdo_en, "R5", 32'(sdo_en), 32'd0);
        rfs_n = 1'b1; wt(HALF);
    endtask

    initial begin
        void'($urandom(32'd4242));
        sclk = 1'b0; rfs_n = 1'b1; addr_sel = 1'b0; reg_idx = '0;
        res_valid = 1'b0; res_data = '0;
        for (int g = 0; g < NREG; g++) begin
            regs[g] = W'($urandom);
            regs_flat[g*W +: W] = regs[g];
        end
        wt(3);
        chk(drdy_n == 1'b1 && sdo_en == 1'b0, "R1", {30'd0, drdy_n, sdo_en}, 32'd2);
        rst_n = 1'b1;
        wt(3);
        chk(drdy_n == 1'b1 && sdo_en == 1'b0, "R1", {30'd0, drdy_n, sdo_en}, 32'd2);
        // result read while not ready
        read_word(1'b0, 0, 0, 0, '0);
        // register read while not ready, result arrives mid-transfer
        read_word(1'b1, 2, 0, 5, 24'hA5C3F0);
        read_word(1'b0, 0, 0, 0, '0);
        push(24'h800001);
        wt(4);
        chk(drdy_n == 1'b0, "R2", 32'(drdy_n), 32'd0);
        read_word(1'b0, 0, 0, 0, '0);
        push(24'h5A5A5A);
        wt(4);
        read_word(1'b0, 0, 1, 0, '0);
        push(24'h123456);
        wt(4);
        // result arriving during result reads, early and late
        read_word(1'b0, 0, 2, 10, 24'hFEDCBA);
        chk(drdy_n == 1'b0, "R9", 32'(drdy_n), 32'd0);
        read_word(1'b0, 0, 0, 22, 24'h0F0F0F);
        read_word(1'b0, 0, 2, 0, '0);
        read_word(1'b1, 3, 1, 0, '0);
        for (int k = 0; k < 30; k++) begin
            if (($urandom % 3) == 0) begin
                push(W'($urandom));
                wt(4);
            end
            read_word(1'($urandom % 2), int'($urandom % NREG), 2,
                      (($urandom % 4) == 0) ? int'(1 + $urandom % 22) : 0, W'($urandom));
        end
        done_flag = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule